// File: doc/BRIEF.md
# Dual-Clock True Dual-Port RAM

A synthesizable memory with two symmetric ports, A and B. Each port has its own clock, address, write data, byte-lane write mask, port enable, write request and synchronous output clear. The port enable asks for a read. A write happens only when the enable and the write request are both high. Each port returns its read word after its own parameterized latency. A data word that one port writes can later be read through the other port.

Each port has its own parameter that sets what its read output shows when the same port writes and reads in one cycle. There are three choices:
- no-change: the read is dropped.
- read-first: the output shows the contents from before the write.
- write-first: the output shows the new word, with masked lanes showing the old contents.

By default port A is read-first and port B is write-first.

The storage is two single-writer banks that are combined by XOR. Each bank is written only from its own clock domain, so no storage cell has two drivers. Addresses at or above the depth parameter are outside the memory. A write to such an address is dropped and a read from it returns zero.

Top module: `tdp_ram`

## Requirements
- R1: A port writes its word only when its enable and write request are both high. Only the lanes whose mask bit is set are written. Mask bit i covers data bits [i*LANE_W +: LANE_W].
- R2: A cycle with the enable high is a read. Its data reaches the port's read output after that port's latency, counted in the port's own clock edges. Extra pipeline stages move only on cycles where the enable is high.
- R3: In no-change mode, a cycle with both the enable and the write request high performs no read. The read output and the pipeline keep their values.
- R4: In read-first mode, a write-and-read cycle returns the word that was stored before the write.
- R5: In write-first mode, a write-and-read cycle returns the new data in the lanes being written and the old contents in the masked lanes.
- R6: When a port's clear is high at an edge of its clock, that port's final output stage becomes zero. The clear takes priority over data that would enter that stage.
- R7: When the address is at or above DEPTH, a write is dropped and a read produces zero.
- R8: While rst_ni is low, every output stage of both ports is zero. The reset acts asynchronously.
- R9: Each port registers only on its own clock. A word written through one port can be read through the other.
- R10: When a port has its enable and its clear both low, its read output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| clk_b_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Active-low asynchronous reset of both output pipelines |
| a_en_i | input | 1 | Port A enable (read request) |
| a_we_i | input | 1 | Port A write request |
| a_be_i | input | DATA_W/LANE_W | Port A lane write mask |
| a_addr_i | input | ADDR_W | Port A word address |
| a_wdata_i | input | DATA_W | Port A write data |
| a_clr_i | input | 1 | Port A synchronous output clear |
| a_rdata_o | output | DATA_W | Port A read data |
| b_en_i | input | 1 | Port B enable (read request) |
| b_we_i | input | 1 | Port B write request |
| b_be_i | input | DATA_W/LANE_W | Port B lane write mask |
| b_addr_i | input | ADDR_W | Port B word address |
| b_wdata_i | input | DATA_W | Port B write data |
| b_clr_i | input | 1 | Port B synchronous output clear |
| b_rdata_o | output | DATA_W | Port B read data |

## Verification
The hardest situation to reach is both ports working at the same time on two unrelated clocks. Traffic must be heavy enough to show that the two banks stay consistent, yet must never have both ports on one address, because that result is undefined. The stimulus runs the two ports in parallel threads on clocks of 10 ns and 12 ns, with port A limited to even addresses and port B to odd ones. Two instances are driven with the same inputs. One covers read-first and write-first, the other covers no-change, and each has multi-stage pipelines, so every same-port collision mode is hit with random masks, clears and enable gaps.

// File: rtl/tdp_ram_pkg.sv
package tdp_ram_pkg;
  typedef enum logic [1:0] {
    COLL_NO_CHANGE   = 2'd0,
    COLL_READ_FIRST  = 2'd1,
    COLL_WRITE_FIRST = 2'd2
  } coll_mode_e;
endpackage

// File: rtl/tdp_ram_store.sv
// Two single-writer banks; the stored word is bank_a ^ bank_b.
module tdp_ram_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned LANES = DATA_W / LANE_W,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_a_i,
  input  logic              a_wr_i,
  input  logic [LANES-1:0]  a_be_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_word_o,
  output logic              a_hit_o,
  input  logic              clk_b_i,
  input  logic              b_wr_i,
  input  logic [LANES-1:0]  b_be_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_word_o,
  output logic              b_hit_o
);
  localparam logic [ADDR_W:0] DEPTH_C = DEPTH[ADDR_W:0];

  logic [DATA_W-1:0] bank_a [DEPTH];
  logic [DATA_W-1:0] bank_b [DEPTH];
  logic [IDX_W-1:0]  a_idx, b_idx;

  assign a_hit_o = {1'b0, a_addr_i} < DEPTH_C;
  assign b_hit_o = {1'b0, b_addr_i} < DEPTH_C;
  assign a_idx   = a_hit_o ? a_addr_i[IDX_W-1:0] : '0;
  assign b_idx   = b_hit_o ? b_addr_i[IDX_W-1:0] : '0;

  assign a_word_o = a_hit_o ? (bank_a[a_idx] ^ bank_b[a_idx]) : '0;
  assign b_word_o = b_hit_o ? (bank_a[b_idx] ^ bank_b[b_idx]) : '0;

  always_ff @(posedge clk_a_i) begin
    if (a_wr_i && a_hit_o) begin
      for (int l = 0; l < LANES; l++) begin
        if (a_be_i[l])
          bank_a[a_idx][l*LANE_W +: LANE_W] <= a_wdata_i[l*LANE_W +: LANE_W]
                                             ^ bank_b[a_idx][l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk_b_i) begin
    if (b_wr_i && b_hit_o) begin
      for (int l = 0; l < LANES; l++) begin
        if (b_be_i[l])
          bank_b[b_idx][l*LANE_W +: LANE_W] <= b_wdata_i[l*LANE_W +: LANE_W]
                                             ^ bank_a[b_idx][l*LANE_W +: LANE_W];
      end
    end
  end
endmodule

// File: rtl/tdp_ram_port.sv
module tdp_ram_port
  import tdp_ram_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LAT    = 1,
  parameter coll_mode_e  MODE   = COLL_READ_FIRST,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic              clr_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic              inr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] nxt;
  logic              adv;
  logic [DATA_W-1:0] stg [LAT];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged[l*LANE_W +: LANE_W] = be_i[l] ? wdata_i[l*LANE_W +: LANE_W]
                                                : old_i[l*LANE_W +: LANE_W];
  end

  assign adv = en_i && !(MODE == COLL_NO_CHANGE && we_i);

  always_comb begin
    nxt = old_i;
    if (MODE == COLL_WRITE_FIRST && we_i) nxt = merged;
    if (!inr_i) nxt = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < LAT; k++) stg[k] <= '0;
    end else begin
      if (adv) begin
        stg[0] <= nxt;
        for (int k = 1; k < LAT; k++) stg[k] <= stg[k-1];
      end
      if (clr_i) stg[LAT-1] <= '0;
    end
  end

  assign rdata_o = stg[LAT-1];

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> rdata_o == '0);
  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(rdata_o));
  p_oob_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && !inr_i && !(clr_i && LAT == 1)) |=> stg[0] == '0);

  if (MODE == COLL_NO_CHANGE) begin : g_nc
    p_nc_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && we_i && !clr_i) |=> $stable(rdata_o));
  end else if (MODE == COLL_READ_FIRST) begin : g_rf
    p_rf_old_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv && inr_i && !(clr_i && LAT == 1)) |=> stg[0] == $past(old_i));
  end else begin : g_wf
    p_wf_new_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv && inr_i && we_i && !(clr_i && LAT == 1)) |=> stg[0] == $past(merged));
  end
endmodule

// File: rtl/tdp_ram.sv
module tdp_ram
  import tdp_ram_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LAT_A  = 1,
  parameter int unsigned LAT_B  = 1,
  parameter coll_mode_e  MODE_A = COLL_READ_FIRST,
  parameter coll_mode_e  MODE_B = COLL_WRITE_FIRST,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic              clk_a_i,
  input  logic              clk_b_i,
  input  logic              rst_ni,
  input  logic              a_en_i,
  input  logic              a_we_i,
  input  logic [LANES-1:0]  a_be_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  input  logic              a_clr_i,
  output logic [DATA_W-1:0] a_rdata_o,
  input  logic              b_en_i,
  input  logic              b_we_i,
  input  logic [LANES-1:0]  b_be_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  input  logic              b_clr_i,
  output logic [DATA_W-1:0] b_rdata_o
);
  logic [DATA_W-1:0] a_word, b_word;
  logic              a_hit, b_hit;

  tdp_ram_store #(
    .DATA_W(DATA_W), .LANE_W(LANE_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
  ) i_store (
    .clk_a_i  (clk_a_i),
    .a_wr_i   (a_en_i & a_we_i),
    .a_be_i   (a_be_i),
    .a_addr_i (a_addr_i),
    .a_wdata_i(a_wdata_i),
    .a_word_o (a_word),
    .a_hit_o  (a_hit),
    .clk_b_i  (clk_b_i),
    .b_wr_i   (b_en_i & b_we_i),
    .b_be_i   (b_be_i),
    .b_addr_i (b_addr_i),
    .b_wdata_i(b_wdata_i),
    .b_word_o (b_word),
    .b_hit_o  (b_hit)
  );

  tdp_ram_port #(
    .DATA_W(DATA_W), .LANE_W(LANE_W), .LAT(LAT_A), .MODE(MODE_A)
  ) i_port_a (
    .clk_i  (clk_a_i),
    .rst_ni (rst_ni),
    .en_i   (a_en_i),
    .we_i   (a_we_i),
    .clr_i  (a_clr_i),
    .be_i   (a_be_i),
    .wdata_i(a_wdata_i),
    .old_i  (a_word),
    .inr_i  (a_hit),
    .rdata_o(a_rdata_o)
  );

  tdp_ram_port #(
    .DATA_W(DATA_W), .LANE_W(LANE_W), .LAT(LAT_B), .MODE(MODE_B)
  ) i_port_b (
    .clk_i  (clk_b_i),
    .rst_ni (rst_ni),
    .en_i   (b_en_i),
    .we_i   (b_we_i),
    .clr_i  (b_clr_i),
    .be_i   (b_be_i),
    .wdata_i(b_wdata_i),
    .old_i  (b_word),
    .inr_i  (b_hit),
    .rdata_o(b_rdata_o)
  );
endmodule

// File: tb/test_tdp_ram.sv
`timescale 1ns/1ps
module test_tdp_ram;
  localparam int DW  = 32;
  localparam int LW  = 8;
  localparam int NL  = DW / LW;
  localparam int DEP = 12;
  localparam int AW  = 4;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic a_en = 0, a_we = 0, a_clr = 0, b_en = 0, b_we = 0, b_clr = 0;
  logic [NL-1:0] a_be = '0, b_be = '0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wd = '0, b_wd = '0;
  logic [DW-1:0] a_rd0, b_rd0, a_rd1, b_rd1;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R8";
  bit done = 0;

  always #5 clk_a = ~clk_a;
  always #6 clk_b = ~clk_b;

  // instance 0: A read-first lat 1, B write-first lat 3
  tdp_ram #(.DATA_W(DW), .LANE_W(LW), .DEPTH(DEP), .ADDR_W(AW), .LAT_A(1), .LAT_B(3),
    .MODE_A(tdp_ram_pkg::COLL_READ_FIRST), .MODE_B(tdp_ram_pkg::COLL_WRITE_FIRST)
  ) i_tdp_ram (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n),
    .a_en_i(a_en), .a_we_i(a_we), .a_be_i(a_be), .a_addr_i(a_addr), .a_wdata_i(a_wd),
    .a_clr_i(a_clr), .a_rdata_o(a_rd0),
    .b_en_i(b_en), .b_we_i(b_we), .b_be_i(b_be), .b_addr_i(b_addr), .b_wdata_i(b_wd),
    .b_clr_i(b_clr), .b_rdata_o(b_rd0));

  // instance 1: both no-change, A lat 2, B lat 1
  tdp_ram #(.DATA_W(DW), .LANE_W(LW), .DEPTH(DEP), .ADDR_W(AW), .LAT_A(2), .LAT_B(1),
    .MODE_A(tdp_ram_pkg::COLL_NO_CHANGE), .MODE_B(tdp_ram_pkg::COLL_NO_CHANGE)
  ) i_tdp_ram_nc (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n),
    .a_en_i(a_en), .a_we_i(a_we), .a_be_i(a_be), .a_addr_i(a_addr), .a_wdata_i(a_wd),
    .a_clr_i(a_clr), .a_rdata_o(a_rd1),
    .b_en_i(b_en), .b_we_i(b_we), .b_be_i(b_be), .b_addr_i(b_addr), .b_wdata_i(b_wd),
    .b_clr_i(b_clr), .b_rdata_o(b_rd1));

  // ---------------- reference model ----------------
  logic [DW-1:0] mem [DEP];
  logic [3:0][DW-1:0] pa0 = '0, pa1 = '0, pb0 = '0, pb1 = '0;

  function automatic logic [DW-1:0] mix(logic [DW-1:0] old, logic [DW-1:0] wd, logic [NL-1:0] be);
    logic [DW-1:0] r = old;
    for (int l = 0; l < NL; l++) if (be[l]) r[l*LW +: LW] = wd[l*LW +: LW];
    return r;
  endfunction

  task automatic step(inout logic [3:0][DW-1:0] p, input int lat, input logic adv,
                      input logic clr, input logic [DW-1:0] v);
    if (adv) begin
      for (int k = 3; k > 0; k--) p[k] = p[k-1];
      p[0] = v;
    end
    if (clr) p[lat-1] = '0;
  endtask

  always @(posedge clk_a) begin
    if (!rst_n) begin
      pa0 = '0; pa1 = '0;
    end else begin
      logic hit, wr;
      logic [DW-1:0] old;
      hit = int'(a_addr) < DEP;
      old = hit ? mem[a_addr] : '0;
      wr  = a_en && a_we;
      step(pa0, 1, a_en, a_clr, old);
      step(pa1, 2, a_en && !wr, a_clr, old);
      if (wr && hit) mem[a_addr] = mix(old, a_wd, a_be);
    end
  end

  always @(posedge clk_b) begin
    if (!rst_n) begin
      pb0 = '0; pb1 = '0;
    end else begin
      logic hit, wr;
      logic [DW-1:0] old, nw;
      hit = int'(b_addr) < DEP;
      old = hit ? mem[b_addr] : '0;
      wr  = b_en && b_we;
      nw  = mix(old, b_wd, b_be);
      step(pb0, 3, b_en, b_clr, (wr && hit) ? nw : old);
      step(pb1, 1, b_en && !wr, b_clr, old);
      if (wr && hit) mem[b_addr] = nw;
    end
  end

  task automatic chk(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk_a) if (rst_n && !done) begin
    chk("A inst0", a_rd0, pa0[0]);
    chk("A inst1", a_rd1, pa1[1]);
  end
  always @(negedge clk_b) if (rst_n && !done) begin
    chk("B inst0", b_rd0, pb0[2]);
    chk("B inst1", b_rd1, pb1[0]);
  end

  // ---------------- stimulus ----------------
  task automatic a_cyc(logic en, logic we, logic [NL-1:0] be, logic [AW-1:0] ad,
                       logic [DW-1:0] wd, logic clr);
    @(negedge clk_a);
    a_en = en; a_we = we; a_be = be; a_addr = ad; a_wd = wd; a_clr = clr;
  endtask
  task automatic b_cyc(logic en, logic we, logic [NL-1:0] be, logic [AW-1:0] ad,
                       logic [DW-1:0] wd, logic clr);
    @(negedge clk_b);
    b_en = en; b_we = we; b_be = be; b_addr = ad; b_wd = wd; b_clr = clr;
  endtask
  task automatic a_rand(int n, bit even);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] ad = AW'($urandom);
      if (even) ad[0] = 1'b0;
      a_cyc(($urandom % 4) != 0, $urandom % 2, NL'($urandom), ad, $urandom, ($urandom % 8) == 0);
    end
    a_cyc(0, 0, '0, '0, '0, 0);
  endtask
  task automatic b_rand(int n, bit odd);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] ad = AW'($urandom);
      if (odd) ad[0] = 1'b1;
      b_cyc(($urandom % 4) != 0, $urandom % 2, NL'($urandom), ad, $urandom, ($urandom % 8) == 0);
    end
    b_cyc(0, 0, '0, '0, '0, 0);
  endtask

  initial begin
    cur_req = "R8";
    repeat (4) @(negedge clk_a);
    chk("reset A inst0", a_rd0, '0);
    chk("reset A inst1", a_rd1, '0);
    chk("reset B inst0", b_rd0, '0);
    chk("reset B inst1", b_rd1, '0);
    @(negedge clk_a); rst_n = 1'b1;

    cur_req = "R4";   // full writes on A: read-first and no-change collisions
    for (int i = 0; i < DEP; i++) a_cyc(1, 1, '1, AW'(i), 32'hA500_0000 | i, 0);
    cur_req = "R2";   // plain reads on A, latency 1 and 2
    for (int i = 0; i < 16; i++) a_cyc(1, 0, '0, AW'(i), '0, 0);
    cur_req = "R10";  // enable low: outputs hold
    for (int i = 0; i < 6; i++) a_cyc(0, 1, '1, AW'(i), $urandom, 0);
    a_cyc(0, 0, '0, '0, '0, 0);
    repeat (3) @(negedge clk_a);

    cur_req = "R9";   // B reads what A wrote
    for (int i = 0; i < 16; i++) b_cyc(1, 0, '0, AW'(i), '0, 0);
    cur_req = "R5";   // masked writes on B: write-first and no-change
    for (int i = 0; i < DEP; i++) b_cyc(1, 1, NL'($urandom), AW'(i), $urandom, 0);
    cur_req = "R1";   // readback of masked result; we without en must not write
    for (int i = 0; i < DEP; i++) b_cyc(0, 1, '1, AW'(i), 32'hDEAD_BEEF, 0);
    for (int i = 0; i < DEP; i++) b_cyc(1, 0, '0, AW'(i), '0, 0);
    cur_req = "R7";   // out-of-range writes dropped, reads zero
    for (int i = DEP; i < 16; i++) b_cyc(1, 1, '1, AW'(i), 32'h1234_5678, 0);
    for (int i = 8; i < 16; i++) b_cyc(1, 0, '0, AW'(i), '0, 0);
    b_cyc(0, 0, '0, '0, '0, 0);
    repeat (4) @(negedge clk_b);

    cur_req = "R6";   // clear with and without enable
    a_cyc(1, 0, '0, 4'd3, '0, 0);
    a_cyc(1, 0, '0, 4'd4, '0, 1);
    a_cyc(0, 0, '0, 4'd5, '0, 1);
    a_cyc(1, 0, '0, 4'd6, '0, 0);
    a_cyc(1, 0, '0, 4'd7, '0, 1);
    a_cyc(0, 0, '0, '0, '0, 0);
    b_cyc(1, 0, '0, 4'd2, '0, 0);
    b_cyc(1, 1, '1, 4'd2, 32'h0F0F_0F0F, 1);
    b_cyc(1, 0, '0, 4'd2, '0, 0);
    b_cyc(0, 0, '0, '0, '0, 1);
    b_cyc(0, 0, '0, '0, '0, 0);
    repeat (4) @(negedge clk_b);

    cur_req = "R3";   // random single-port traffic, all collision modes
    a_rand(300, 0);
    repeat (3) @(negedge clk_a);
    b_rand(300, 0);
    repeat (5) @(negedge clk_b);

    cur_req = "R9";   // both ports active on disjoint addresses
    fork
      a_rand(500, 1);
      b_rand(400, 1);
    join
    repeat (6) @(negedge clk_b);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule